// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat burst inside a synchronous pipelined SRAM. Two active-low address strobes are sampled on each rising clock edge, one from the processor side and one from the controller side. When either strobe is low, the block captures the full external address and restarts its burst count at zero.

On later edges, the active-low advance input steps a two-bit counter. Only the two lowest address bits are derived from this counter. The upper bits hold the captured value until the next strobe.

A static mode level chooses how the low bits are formed from the captured start word and the count. With mode high the low bits are the captured low bits XOR the count (interleaved order). With mode low they are the captured low bits plus the count, modulo four (linear order). The mode level is not registered: the output follows it within the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `addr_out` is 16'h0000, whatever the strobes and address bus carry.
- R2: On a rising edge where `ads_cpu_n` or `ads_ctl_n` is low, the value of `addr_in` is captured. After that edge, `addr_out` equals that value exactly, in either mode.
- R3: When a strobe and `adv_n` are both low on the same edge, the strobe takes priority. The count restarts at zero, so `addr_out` equals the captured address.
- R4: On an edge with both strobes high and `adv_n` high, the count and the captured address are unchanged. `addr_out` stays the same while `burst_mode` is steady.
- R5: While both strobes are high, `addr_out[15:2]` does not change, whatever `addr_in` carries.
- R6: With `burst_mode` = 0 (linear), `addr_out[1:0]` = (captured low bits + count) mod 4. For a start of 01 this gives 01, 10, 11, 00.
- R7: With `burst_mode` = 1 (interleaved), `addr_out[1:0]` = captured low bits XOR count. For a start of 01 this gives 01, 00, 11, 10.
- R8: After four advances following a load, the count wraps to zero and `addr_out` returns to the captured address.
- R9: A change of `burst_mode` alters `addr_out[1:0]` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all sampled inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_cpu_n | input | 1 | Processor-side address strobe, active low |
| ads_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_mode | input | 1 | Static order select: 1 = interleaved, 0 = linear |
| addr_in | input | 16 | External word address |
| addr_out | output | 16 | Current internal word address |

## Verification
Loads, advances and holds each take effect on `addr_out` one rising edge after the stimulus. A change of `burst_mode` shows up on `addr_out` with no clock edge at all.

The bench changes inputs 2 ns after a falling edge. It compares `addr_out` against its behavioural model at the next falling edge, which falls after exactly one rising edge. For the mode check, the bench flips `burst_mode` in mid-cycle and compares 1 ns later, before any edge, so a registered mode path would be caught.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } burst_cmd_e;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
    import burst_pkg::*;
#(
    parameter int NUM_STROBE = 2
) (
    input  logic [NUM_STROBE-1:0] strobe_n,
    input  logic                  adv_n,
    output burst_cmd_e            cmd
);
    logic any_strobe;

    always_comb begin
        any_strobe = ~(&strobe_n);
        // a strobe outranks advance on the same edge
        if (any_strobe)
            cmd = CMD_LOAD;
        else if (!adv_n)
            cmd = CMD_STEP;
        else
            cmd = CMD_HOLD;
    end
endmodule

// File: rtl/burst_state_reg.sv
module burst_state_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [BURST_W-1:0] cnt_q
);
    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_LOAD: begin
                st_d.base = addr_in;
                st_d.cnt  = '0;
            end
            CMD_STEP: st_d.cnt = st_q.cnt + BURST_W'(1);
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign base_q = st_q.base;
    assign cnt_q  = st_q.cnt;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] start_lo,
    input  logic [BURST_W-1:0] cnt,
    input  burst_order_e       order,
    output logic [BURST_W-1:0] word_lo
);
    logic [BURST_W-1:0] xor_lo;
    logic [BURST_W-1:0] lin_lo;

    for (genvar b = 0; b < BURST_W; b++) begin : g_xor_bit
        assign xor_lo[b] = start_lo[b] ^ cnt[b];
    end

    always_comb begin
        lin_lo  = start_lo + cnt;
        word_lo = (order == ORDER_XOR) ? xor_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_cpu_n,
    input  logic              ads_ctl_n,
    input  logic              adv_n,
    input  logic              burst_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BURST_W;

    burst_cmd_e         cmd;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] word_lo;
    burst_order_e       order;

    assign order = burst_order_e'(burst_mode);

    burst_cmd_dec #(.NUM_STROBE(2)) u_dec (
        .strobe_n ({ads_ctl_n, ads_cpu_n}),
        .adv_n    (adv_n),
        .cmd      (cmd)
    );

    burst_state_reg #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .addr_in (addr_in),
        .base_q  (base_q),
        .cnt_q   (cnt_q)
    );

    burst_order_map #(.BURST_W(BURST_W)) u_map (
        .start_lo (base_q[BURST_W-1:0]),
        .cnt      (cnt_q),
        .order    (order),
        .word_lo  (word_lo)
    );

    assign addr_out = {base_q[ADDR_W-1 -: HI_W], word_lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W  = 16,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ads_cpu_n,
    input logic              ads_ctl_n,
    input logic              adv_n,
    input logic              burst_mode,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (addr_out == '0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_cpu_n || !ads_ctl_n) |=> (addr_out == $past(addr_in)));

    // R3
    strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ads_cpu_n || !ads_ctl_n) && !adv_n)
        |=> (addr_out[BURST_W-1:0] == $past(addr_in[BURST_W-1:0])));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_cpu_n && ads_ctl_n && adv_n)
        |=> ((burst_mode != $past(burst_mode)) || $stable(addr_out)));

    // R5
    upper_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_cpu_n && ads_ctl_n) |=> $stable(addr_out[ADDR_W-1:BURST_W]));

    // R6
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_cpu_n && ads_ctl_n && !adv_n && !burst_mode)
        |=> (burst_mode ||
             (addr_out[BURST_W-1:0] == BURST_W'($past(addr_out[BURST_W-1:0]) + 1'b1))));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (.*);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ads_cpu_n = 1'b1;
    logic        ads_ctl_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        burst_mode = 1'b1;
    logic [15:0] addr_in = 16'h0000;
    logic [15:0] addr_out;

    int    checks = 0;
    int    errors = 0;
    bit    run_cmp = 0;
    string cur_req = "R2";
    int    m_base = 0;
    int    m_cnt = 0;

    always #10 clk = ~clk;

    burst_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n),
        .adv_n(adv_n), .burst_mode(burst_mode), .addr_in(addr_in), .addr_out(addr_out)
    );

    // behavioural reference: start word plus a modulo-4 beat number
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_base = 0;
            m_cnt  = 0;
        end else if (!ads_cpu_n || !ads_ctl_n) begin
            m_base = int'(addr_in);
            m_cnt  = 0;
        end else if (!adv_n) begin
            m_cnt = (m_cnt + 1) % 4;
        end
    end

    function automatic logic [15:0] expected();
        int lo = m_base % 4;
        int w  = burst_mode ? (lo ^ m_cnt) : ((lo + m_cnt) % 4);
        return 16'((m_base / 4) * 4 + w);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp) check(cur_req, addr_out, expected());
    end

    task automatic drive(logic cpu, logic ctl, logic adv, logic [15:0] a, logic m, string tag);
        @(negedge clk);
        #2;
        ads_cpu_n  = cpu;
        ads_ctl_n  = ctl;
        adv_n      = adv;
        addr_in    = a;
        burst_mode = m;
        cur_req    = tag;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL R1 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: strobe active during reset must not disturb the zero output
        ads_cpu_n = 1'b0;
        addr_in   = 16'hBEEF;
        repeat (3) @(negedge clk);
        check("R1", addr_out, 16'h0000);
        #2;
        ads_cpu_n = 1'b1;
        rst_n = 1'b1;
        run_cmp = 1;

        // R2 + R6 + R8: linear burst from start 01, addr_in noise ignored (R5)
        drive(0, 1, 1, 16'h1235, 0, "R2");
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 16'($urandom), 0, "R6");
        drive(1, 1, 1, 16'h0000, 0, "R4");
        @(negedge clk);
        #1;
        check("R8", addr_out, 16'h1235);

        // R2 via controller strobe + R7 interleaved sequence
        drive(1, 0, 1, 16'hABC9, 1, "R2");
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 16'h5555, 1, "R7");
        drive(1, 1, 1, 16'hFFFF, 1, "R5");
        @(negedge clk);
        #1;
        check("R8", addr_out, 16'hABC9);

        // R3: both strobes and advance together
        drive(0, 0, 0, 16'h7FFE, 1, "R3");
        @(negedge clk);
        #1;
        check("R3", addr_out, 16'h7FFE);
        drive(1, 1, 0, 16'h0001, 0, "R6");
        drive(1, 1, 0, 16'h0002, 0, "R6");
        for (int i = 0; i < 3; i++) drive(1, 1, 1, 16'($urandom), 0, "R4");

        // R9: mode flip mid-cycle, start 01 after one advance
        drive(0, 1, 1, 16'h4441, 0, "R2");
        drive(1, 1, 0, 16'h0000, 0, "R6");
        drive(1, 1, 1, 16'h0000, 0, "R4");
        #1;
        check("R6", addr_out, 16'h4442);
        burst_mode = 1'b1;
        #1;
        check("R9", addr_out, 16'h4440);
        burst_mode = 1'b0;
        #1;
        check("R9", addr_out, 16'h4442);

        // mixed stimulus against the model
        for (int i = 0; i < 400; i++) begin
            logic s1 = ($urandom % 6) == 0;
            logic s2 = ($urandom % 8) == 0;
            drive(!s1, !s2, 1'($urandom), 16'($urandom),
                  (i % 50) < 25 ? 1'b1 : 1'b0, (s1 || s2) ? "R2" : "R5");
        end
        @(negedge clk);
        #1;
        run_cmp = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule